// File: doc/BRIEF.md
# Dirty-Victim Write Buffer

This block sits between a write-back cache and the next memory level. When a cache miss pushes out a modified block, the cache hands that block over together with its block address. The block is held here, so the memory read for the missing block goes out first. The held block is written to memory afterwards, during cycles when no read is waiting. Victims that are not modified are taken in the same cycle and thrown away, so such a miss costs only the fill.

The cache sends its miss reads through this block. A read whose block address matches a held entry is answered from the buffer one cycle after acceptance, and memory sees no read for it. Any other read is passed to memory, and the returned fill beat is forwarded to the cache. A separate query port tells the cache at once whether a block address is currently held. When the buffer serves a write-through cache, each store enters as a modified entry and completes in the cycle it is offered, unless the buffer is full.

The memory side has two channels, one for reads and one for writes. They are never active together. A write is offered only when no read is waiting or being offered.

Top module: `wb_evict_buf`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the buffer holds nothing: `full`=0, `ev_ready`=1, `rd_ready`=1, `mrd_valid`=0, `mwr_valid`=0, `rsp_valid`=0, and `q_hit`=0 for every address.
- R2: A victim offered with `ev_dirty`=1 while `full`=0 sees `ev_ready`=1 and is taken at that clock edge. The same address and data later appear on a write handshake (`mwr_valid`&`mwr_ready`).
- R3: A victim offered with `ev_dirty`=0 is taken and discarded. It never produces a write, never matches a read or a query, and never makes `full` rise.
- R4: The buffer holds DEPTH entries (default 2). `full`=1 exactly when all of them are occupied, and `ev_ready`=0 then. An offered victim waits, holding its inputs, until a drain frees an entry.
- R5: A read accepted (`rd_valid`&`rd_ready`) whose address matches a held entry gives `rsp_valid`=1 one cycle later, with that entry's data and `rsp_from_buf`=1. No memory read is issued for it.
- R6: Any other accepted read raises `mrd_valid` with `mrd_addr`=the read address in the next cycle and holds both until `mrd_ready`. `rd_ready` stays 0 until the fill beat (`fill_valid`) has been taken. `rsp_valid`=1 follows one cycle after the fill beat, with `fill_data` and `rsp_from_buf`=0.
- R7: Reads have priority. `mwr_valid` is 0 whenever `rd_valid` or `mrd_valid` is 1, and `mrd_valid` and `mwr_valid` are never both 1. A dirty victim offered in the same cycle as its miss read is written only in a cycle after the fill read handshake.
- R8: Held entries are written out oldest first, one entry per write handshake.
- R9: When two held entries share an address, a matching read returns the data of the younger entry.
- R10: `q_hit` is a combinational function of `q_addr`. It is 1 exactly when a held entry has that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Victim block offered by the cache |
| ev_ready | output | 1 | Victim can be taken this cycle |
| ev_dirty | input | 1 | Victim is modified (1) or clean (0) |
| ev_addr | input | ADDR_W | Victim block address |
| ev_data | input | DATA_W | Victim block data |
| full | output | 1 | All entries occupied |
| q_addr | input | ADDR_W | Block address to look up |
| q_hit | output | 1 | q_addr is held in the buffer |
| rd_valid | input | 1 | Miss read request from the cache |
| rd_ready | output | 1 | Miss read can be accepted |
| rd_addr | input | ADDR_W | Miss read block address |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_data | output | DATA_W | Read response data |
| rsp_from_buf | output | 1 | Response came from a held entry |
| mrd_valid | output | 1 | Memory read request |
| mrd_ready | input | 1 | Memory accepts the read request |
| mrd_addr | output | ADDR_W | Memory read block address |
| fill_valid | input | 1 | Fill beat from memory |
| fill_data | input | DATA_W | Fill data |
| mwr_valid | output | 1 | Memory write request |
| mwr_ready | input | 1 | Memory accepts the write |
| mwr_addr | output | ADDR_W | Memory write block address |
| mwr_data | output | DATA_W | Memory write data |

## Verification
The hardest situation to reach is a dirty victim and its miss read arriving in the same cycle while memory is ready to accept a write at once. Only then can a wrong arbiter let the write overtake the fill read. The bench drives both requests on one edge with the write channel already open. It records the cycle of each memory handshake and checks that the read handshake comes strictly first. A second hard case is a victim stalled on a full buffer. The bench gets there by holding the write channel closed until two entries are held, then opening it while a third victim is waiting.

// File: rtl/evb_pkg.sv
// Shared types for the dirty-victim write buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package evb_pkg;
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,   // ready for a new miss read
        MS_ASK  = 2'd1,   // memory read request offered
        MS_WAIT = 2'd2    // waiting for the fill beat
    } miss_state_e;
endpackage

// File: rtl/evb_match.sv
// Associative lookup over the ring of held entries.
// Walks the entries from oldest to youngest, so the youngest match wins.
// Assumes: DEPTH is a power of two, so the ring index wraps without extra logic.
module evb_match #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
    input  logic [DEPTH-1:0][DATA_W-1:0] datas,
    input  logic [PTR_W-1:0]             oldest,
    input  logic [ADDR_W-1:0]            key,
    output logic                         hit,
    output logic [DATA_W-1:0]            data
);
    logic [PTR_W-1:0] idx;

    // Scan in age order; a later (younger) match overrides an earlier one.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        idx  = '0;
        for (int a = 0; a < DEPTH; a++) begin
            idx = oldest + a[PTR_W-1:0];
            if (vld[idx] && (addrs[idx] == key)) begin
                hit  = 1'b1;
                data = datas[idx];
            end
        end
    end
endmodule

// File: rtl/evb_store.sv
// Ring of DEPTH held victim entries with push at the tail and pop at the head.
// Two lookups run in parallel: one for miss reads, one for the query port.
// Assumes: no push while full, no pop while empty (the top ensures both).
module evb_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              q_hit
);
    logic [DEPTH-1:0]             vld_q;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [PTR_W-1:0]             wr_ptr_q;
    logic [PTR_W-1:0]             rd_ptr_q;
    logic [DATA_W-1:0]            q_data_unused;

    // Occupancy flags and ring pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) begin
                vld_q[wr_ptr_q] <= 1'b1;
                wr_ptr_q        <= wr_ptr_q + PTR_W'(1);
            end
            if (pop) begin
                vld_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q        <= rd_ptr_q + PTR_W'(1);
            end
        end
    end

    // Entry payload; written only on push, so it needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    assign full      = &vld_q;
    assign empty     = ~|vld_q;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_data = data_q[rd_ptr_q];

    evb_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_lk_match (
        .vld(vld_q), .addrs(addr_q), .datas(data_q), .oldest(rd_ptr_q),
        .key(lk_addr), .hit(lk_hit), .data(lk_data)
    );

    evb_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_q_match (
        .vld(vld_q), .addrs(addr_q), .datas(data_q), .oldest(rd_ptr_q),
        .key(q_addr), .hit(q_hit), .data(q_data_unused)
    );
endmodule

// File: rtl/evb_miss_ctl.sv
// Miss read sequencer: serves buffer hits locally, forwards others to memory.
// Assumes: one fill beat per memory read; reads are handled one at a time.
module evb_miss_ctl
    import evb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              mrd_valid,
    input  logic              mrd_ready,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_from_buf,
    output logic              read_pending
);
    miss_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;

    // Sequence the read and register the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= MS_IDLE;
            addr_q       <= '0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_from_buf <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                MS_IDLE: if (rd_valid) begin
                    if (lk_hit) begin
                        rsp_valid    <= 1'b1;
                        rsp_data     <= lk_data;
                        rsp_from_buf <= 1'b1;
                    end else begin
                        addr_q  <= rd_addr;
                        state_q <= MS_ASK;
                    end
                end
                MS_ASK: if (mrd_ready) state_q <= MS_WAIT;
                MS_WAIT: if (fill_valid) begin
                    rsp_valid    <= 1'b1;
                    rsp_data     <= fill_data;
                    rsp_from_buf <= 1'b0;
                    state_q      <= MS_IDLE;
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end

    assign rd_ready     = (state_q == MS_IDLE);
    assign mrd_valid    = (state_q == MS_ASK);
    assign mrd_addr     = addr_q;
    assign read_pending = rd_valid || (state_q == MS_ASK);
endmodule

// File: rtl/evb_drain.sv
// Write arbiter: offers the oldest entry to memory when no read is pending.
// Assumes: memory acts on the handshake only; valid may drop when a read arrives.
module evb_drain #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              empty,
    input  logic              read_pending,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    output logic              mwr_valid,
    input  logic              mwr_ready,
    output logic [ADDR_W-1:0] mwr_addr,
    output logic [DATA_W-1:0] mwr_data,
    output logic              pop
);
    // Reads win; a write goes out only in a cycle with no read in flight.
    always_comb begin
        mwr_valid = !empty && !read_pending;
        mwr_addr  = head_addr;
        mwr_data  = head_data;
        pop       = mwr_valid && mwr_ready;
    end
endmodule

// File: rtl/wb_evict_buf.sv
// Dirty-victim write buffer between a write-back cache and next-level memory.
// Holds modified victims so the fill read goes first; drains them in order.
// Assumes: a victim is offered no later than its miss read; DEPTH is a power of two.
module wb_evict_buf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic              ev_dirty,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output logic              full,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_hit,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_from_buf,
    output logic              mrd_valid,
    input  logic              mrd_ready,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              mwr_valid,
    input  logic              mwr_ready,
    output logic [ADDR_W-1:0] mwr_addr,
    output logic [DATA_W-1:0] mwr_data
);
    logic              push;
    logic              pop;
    logic              empty;
    logic              read_pending;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;

    // Clean victims are taken and dropped; only modified ones are stored.
    assign ev_ready = !full;
    assign push     = ev_valid && ev_ready && ev_dirty;

    evb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(ev_addr), .push_data(ev_data),
        .pop(pop), .lk_addr(rd_addr), .q_addr(q_addr),
        .full(full), .empty(empty),
        .head_addr(head_addr), .head_data(head_data),
        .lk_hit(lk_hit), .lk_data(lk_data), .q_hit(q_hit)
    );

    evb_miss_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_miss (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_from_buf(rsp_from_buf),
        .read_pending(read_pending)
    );

    evb_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drain (
        .empty(empty), .read_pending(read_pending),
        .head_addr(head_addr), .head_data(head_data),
        .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
        .mwr_addr(mwr_addr), .mwr_data(mwr_data), .pop(pop)
    );
endmodule

// File: rtl/evb_checker.sv
// Protocol and ordering properties of the dirty-victim write buffer.
// Assumes: attached to wb_evict_buf by the bind below.
module evb_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              ev_dirty,
    input logic              full,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              mrd_valid,
    input logic              mrd_ready,
    input logic [ADDR_W-1:0] mrd_addr,
    input logic              mwr_valid
);
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_valid && mwr_valid));                                   // R7
    AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !mwr_valid);                                     // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ev_ready);                                          // R4
    AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(ev_valid && ev_ready && ev_dirty));     // R3
    AST_MRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr))); // R6
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_valid |-> !rd_ready);                                     // R6
endmodule

bind wb_evict_buf evb_checker #(.ADDR_W(ADDR_W)) u_evb_checker (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_dirty(ev_dirty),
    .full(full), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mwr_valid(mwr_valid)
);

// File: tb/test_wb_evict_buf.sv
// Self-checking bench: vector table for pushes and reads, then directed cases.
module test_wb_evict_buf;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0, ev_dirty = 1'b0;
    logic [AW-1:0] ev_addr = '0, q_addr = '0, rd_addr = '0;
    logic [DW-1:0] ev_data = '0;
    logic          rd_valid = 1'b0, mrd_ready = 1'b1, mwr_ready = 1'b0;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          ev_ready, full, q_hit, rd_ready, rsp_valid, rsp_from_buf;
    logic          mrd_valid, mwr_valid;
    logic [DW-1:0] rsp_data, mwr_data;
    logic [AW-1:0] mrd_addr, mwr_addr;

    int tests = 0, fails = 0;
    int cyc = 0, rd_cyc = 0, wcount = 0;
    logic [AW-1:0] wlog_addr [16];
    logic [DW-1:0] wlog_data [16];
    int            wlog_cyc  [16];

    always #5 clk = ~clk;

    wb_evict_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(2)) i_wb_evict_buf (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_dirty(ev_dirty),
        .ev_addr(ev_addr), .ev_data(ev_data), .full(full),
        .q_addr(q_addr), .q_hit(q_hit),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_from_buf(rsp_from_buf),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
        .mwr_addr(mwr_addr), .mwr_data(mwr_data)
    );

    // Memory model: one fill beat the cycle after a read handshake; write log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        fill_valid <= mrd_valid && mrd_ready;
        fill_data  <= {16'hF00D, mrd_addr};
        if (mrd_valid && mrd_ready) rd_cyc <= cyc;
        if (mwr_valid && mwr_ready && wcount < 16) begin
            wlog_addr[wcount] <= mwr_addr;
            wlog_data[wcount] <= mwr_data;
            wlog_cyc[wcount]  <= cyc;
            wcount            <= wcount + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer a victim; for a non-full buffer it must be taken at once (R2).
    task automatic push(input logic dirty, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ev_valid = 1'b1; ev_dirty = dirty; ev_addr = a; ev_data = d;
        #1 chk("R2 ev_ready when not full", ev_ready, 1'b1);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    // Issue a miss read and check response timing, source and data (R5, R6).
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d, input logic from_buf, input string tag);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        #1 chk({tag, " rd_ready"}, rd_ready, 1'b1);
        @(negedge clk);
        rd_valid = 1'b0;
        if (from_buf) begin
            chk({tag, " rsp_valid next cycle"}, rsp_valid, 1'b1);
            chk({tag, " no memory read"}, mrd_valid, 1'b0);
        end else begin
            chk({tag, " mrd_valid"}, mrd_valid, 1'b1);
            chk({tag, " mrd_addr"}, mrd_addr, a);
            chk({tag, " rd_ready low while busy"}, rd_ready, 1'b0);
            @(negedge clk);
            @(negedge clk);
            chk({tag, " rsp_valid after fill"}, rsp_valid, 1'b1);
        end
        chk({tag, " rsp_data"}, rsp_data, exp_d);
        chk({tag, " rsp_from_buf"}, rsp_from_buf, from_buf);
    endtask

    // Vector: {op[1:0] (0 dirty push, 1 clean push, 2 read), addr, data, from_buf}
    localparam logic [50:0] VEC [7] = '{
        {2'd0, 16'h0010, 32'h1111_1111, 1'b0},
        {2'd1, 16'h0020, 32'h2222_2222, 1'b0},
        {2'd2, 16'h0010, 32'h1111_1111, 1'b1},
        {2'd2, 16'h0020, 32'hF00D_0020, 1'b0},
        {2'd0, 16'h0030, 32'h3333_3333, 1'b0},
        {2'd2, 16'h0030, 32'h3333_3333, 1'b1},
        {2'd2, 16'h0044, 32'hF00D_0044, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 full", full, 1'b0);
        chk("R1 ev_ready", ev_ready, 1'b1);
        chk("R1 rd_ready", rd_ready, 1'b1);
        chk("R1 mrd_valid", mrd_valid, 1'b0);
        chk("R1 mwr_valid", mwr_valid, 1'b0);
        chk("R1 rsp_valid", rsp_valid, 1'b0);

        // Table walk with the write channel closed, so nothing drains.
        for (int i = 0; i < 7; i++) begin
            automatic logic [50:0] v = VEC[i];
            case (v[50:49])
                2'd0: push(1'b1, v[48:33], v[32:1]);
                2'd1: push(1'b0, v[48:33], v[32:1]);
                default: do_read(v[48:33], v[32:1], v[0], v[0] ? "R5 buffer hit" : "R6 memory read");
            endcase
        end

        // R4: two dirty entries held -> full; a third victim stalls.
        #1 chk("R4 full with two entries", full, 1'b1);
        @(negedge clk);
        ev_valid = 1'b1; ev_dirty = 1'b1; ev_addr = 16'h0050; ev_data = 32'h5555_5555;
        q_addr = 16'h0050;
        repeat (2) begin
            #1 chk("R4 ev_ready low while full", ev_ready, 1'b0);
            chk("R4 stalled victim not held", q_hit, 1'b0);
            @(negedge clk);
        end
        mwr_ready = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R8 order, R2 payload, R3 clean victim never written
        chk("R3 only dirty victims written", wcount, 3);
        chk("R8 first write addr", wlog_addr[0], 16'h0010);
        chk("R2 first write data", wlog_data[0], 32'h1111_1111);
        chk("R8 second write addr", wlog_addr[1], 16'h0030);
        chk("R8 third write addr", wlog_addr[2], 16'h0050);
        chk("R2 third write data", wlog_data[2], 32'h5555_5555);
        chk("R8 one write per handshake", wlog_cyc[1] - wlog_cyc[0], 1);
        chk("R4 full cleared after drain", full, 1'b0);

        // R7: dirty victim and its miss read in the same cycle, write channel open.
        @(negedge clk);
        ev_valid = 1'b1; ev_dirty = 1'b1; ev_addr = 16'h0060; ev_data = 32'h6666_6666;
        rd_valid = 1'b1; rd_addr = 16'h0070;
        @(negedge clk);
        ev_valid = 1'b0; rd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 victim written once", wcount, 4);
        chk("R7 victim addr", wlog_addr[3], 16'h0060);
        chk("R7 fill read before victim write", (rd_cyc < wlog_cyc[3]) ? 1 : 0, 1);
        chk("R7 fill response data", rsp_data, 32'hF00D_0070);

        // R9/R10: duplicate address; youngest data wins; query port.
        mwr_ready = 1'b0;
        push(1'b1, 16'h0080, 32'hAAAA_0001);
        push(1'b1, 16'h0080, 32'hBBBB_0002);
        do_read(16'h0080, 32'hBBBB_0002, 1'b1, "R9 youngest match");
        q_addr = 16'h0080;
        #1 chk("R10 q_hit on held address", q_hit, 1'b1);
        q_addr = 16'h0081;
        #1 chk("R10 q_hit on absent address", q_hit, 1'b0);
        q_addr = 16'h0020;
        #1 chk("R3 clean victim not held", q_hit, 1'b0);
        mwr_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 older duplicate first", wlog_data[4], 32'hAAAA_0001);
        chk("R8 younger duplicate second", wlog_data[5], 32'hBBBB_0002);

        // R1: reset while holding an entry.
        mwr_ready = 1'b0;
        push(1'b1, 16'h0090, 32'h9999_9999);
        q_addr = 16'h0090;
        #1 chk("R10 held before reset", q_hit, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 entry cleared by reset", q_hit, 1'b0);
        chk("R1 no write after reset", mwr_valid, 1'b0);
        chk("R1 full after reset", full, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule